// File: doc/BRIEF.md
# Static Memory Bank Timing Controller

This block runs an external asynchronous static-memory bus that serves up to four banks. Each bank has its own active-low chip select. A host issues one read or one write at a time on a valid/ready port. The request carries a bank number, an offset within that bank and one data word. The controller then walks through a fixed chain of phases: address setup, chip-select setup, the strobe (output enable for reads, write enable for writes), chip-select hold and address hold. The length of each phase comes from cycle counts that are set separately for each bank.

Each bank also has a data-width setting and a page setting. A narrow bank carries one byte and a wide bank carries a full word. In four-item page mode a read keeps the chip select and output enable asserted after the first access. It then steps the two lowest address bits three more times and captures one item per step. The per-bank settings come in on static input ports.

Top module: `smc_bank_seq`

## Requirements
- R1: While a request is in progress, at most one chip select is low, and it is the one for the requested bank. The bus address on the first busy cycle is the bank number followed by the offset (bank in the upper bits).
- R2: After a request is accepted, the bus address is driven for exactly `t_as` cycles before the chip select goes low.
- R3: The chip select is low for exactly `t_cs` cycles before the strobe begins. The strobe is only ever low while a chip select is low.
- R4: The access strobe lasts `t_acc`+1 cycles. For a read it is output enable and for a write it is write enable. The two are never low together.
- R5: After the strobe the chip select stays low for `t_ch` cycles. The address then stays driven for `t_ah` cycles. The request takes `t_as+t_cs+strobe+t_ch+t_ah` busy cycles in total. After that the done pulse is high for one cycle with ready high.
- R6: A timing value of 0 removes its phase entirely. No dead cycle is inserted.
- R7: A read captures the input bus on the last cycle of the strobe. A wide bank returns the whole word. A narrow bank returns the low byte with the upper bits zero. The result is held in word 0 of the response.
- R8: A write drives the write data during the strobe. A narrow bank drives only the low byte and zeros the upper bits. Writes always perform a single access, whatever the page setting.
- R9: A page read returns four items in response words 0..3. Item k is read at the offset whose two lowest bits are (offset+k) mod 4, with the upper offset bits unchanged. Each page step lasts `t_pg` cycles, or 1 cycle when `t_pg` is 0. Chip select and output enable stay low across all the steps.
- R10: Ready is low from the cycle after acceptance until the address-hold phase has finished. No new request is accepted during that time.
- R11: Each bank's 25-bit timing field in `cfg_timing` sits at bit `25*bank`. It is packed as: `t_pg` [3:0], `t_ah` [7:4], `t_ch` [11:8], `t_acc` [16:12], `t_cs` [20:17], `t_as` [24:21]. In `cfg_wide`, 0 means narrow (1 byte). In `cfg_page4`, 0 means a normal single access.
- R12: After reset all chip selects, output enable and write enable are high, ready is high and done is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | 2 | Target bank |
| req_off | input | 8 | Offset within the bank |
| req_wdata | input | 16 | Write data |
| req_done | output | 1 | One-cycle pulse when a request completes |
| rsp_data | output | 64 | Read results, item k in bits [16k+15:16k] |
| cfg_timing | input | 100 | Per-bank timing fields |
| cfg_wide | input | 4 | Per-bank width (1 = two bytes) |
| cfg_page4 | input | 4 | Per-bank four-item page mode |
| mem_addr | output | 10 | External address {bank, offset} |
| mem_cs_n | output | 4 | Active-low chip selects |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_dout | output | 16 | Data driven to memory |
| mem_din | input | 16 | Data returned from memory |

## Verification
The hardest situation to reach is when zero-length phases fall right next to the page steps. Examples are a page read with `t_pg` of 0 and `t_ch` and `t_ah` of 0, or one whose offset low bits wrap from 3 to 0 in the middle of a page. The stimulus sweeps every bank, both directions and both page settings against a set of timing vectors that are computed arithmetically. These vectors include all-zero and all-maximum values, and the offsets are spread so that every low-bit start position appears. For each access the bench counts the cycles of address, chip select and strobe at the pins and compares them with sums worked out from the fields.

// File: rtl/smc_pkg.sv
package smc_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_ASU  = 3'd1,
    PH_CSU  = 3'd2,
    PH_ACC  = 3'd3,
    PH_PAGE = 3'd4,
    PH_CHD  = 3'd5,
    PH_AHD  = 3'd6
  } phase_e;

  // R11: field packing, most significant first
  typedef struct packed {
    logic [3:0] t_as;
    logic [3:0] t_cs;
    logic [4:0] t_acc;
    logic [3:0] t_ch;
    logic [3:0] t_ah;
    logic [3:0] t_pg;
  } bank_tim_t;

  localparam int TIM_W = $bits(bank_tim_t);

  // number of cycles a phase occupies; 0 means the phase is skipped
  function automatic logic [5:0] phase_len(phase_e ph, bank_tim_t t, logic page_rd);
    case (ph)
      PH_ASU:  return {2'b00, t.t_as};
      PH_CSU:  return {2'b00, t.t_cs};
      PH_ACC:  return {1'b0, t.t_acc} + 6'd1;
      PH_PAGE: return page_rd ? ((t.t_pg == 4'd0) ? 6'd1 : {2'b00, t.t_pg}) : 6'd0;
      PH_CHD:  return {2'b00, t.t_ch};
      PH_AHD:  return {2'b00, t.t_ah};
      default: return 6'd0;
    endcase
  endfunction

  // first phase at or after 'from' with a nonzero length, else idle
  function automatic phase_e first_live(int from, bank_tim_t t, logic page_rd);
    phase_e res = PH_IDLE;
    for (int p = 6; p >= 1; p--) begin
      if (p >= from && phase_len(phase_e'(3'(p)), t, page_rd) != 6'd0)
        res = phase_e'(3'(p));
    end
    return res;
  endfunction

endpackage

// File: rtl/smc_bank_cfg.sv
module smc_bank_cfg
  import smc_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  localparam int BANK_W = $clog2(NUM_BANKS)
) (
  input  logic [NUM_BANKS*TIM_W-1:0] cfg_timing,
  input  logic [NUM_BANKS-1:0]       cfg_wide,
  input  logic [NUM_BANKS-1:0]       cfg_page4,
  input  logic [BANK_W-1:0]          sel,
  output bank_tim_t                  tim,
  output logic                       wide,
  output logic                       page4
);
  bank_tim_t tim_arr [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign tim_arr[b] = cfg_timing[b*TIM_W +: TIM_W];
  end

  assign tim   = tim_arr[sel];
  assign wide  = cfg_wide[sel];
  assign page4 = cfg_page4[sel];
endmodule

// File: rtl/smc_phase_fsm.sv
module smc_phase_fsm
  import smc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  logic      page_rd,
  input  bank_tim_t tim,
  output phase_e    phase,
  output logic [1:0] beat,
  output logic      sample,
  output logic      done
);
  logic [5:0] cnt;
  logic       phase_end;
  logic       page_again;
  phase_e     nxt_ph;
  phase_e     first_ph;

  assign phase_end  = (phase != PH_IDLE) && (cnt == 6'd0);
  assign page_again = (phase == PH_PAGE) && (beat != 2'd3);
  assign nxt_ph     = page_again ? PH_PAGE : first_live(int'(phase) + 1, tim, page_rd);
  assign first_ph   = first_live(1, tim, page_rd);
  assign sample     = (phase == PH_ACC || phase == PH_PAGE) && (cnt == 6'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= 6'd0;
      beat  <= 2'd0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        phase <= first_ph;
        cnt   <= phase_len(first_ph, tim, page_rd) - 6'd1;
        beat  <= 2'd0;
      end else if (phase_end) begin
        phase <= nxt_ph;
        cnt   <= phase_len(nxt_ph, tim, page_rd) - 6'd1;
        if (nxt_ph == PH_PAGE) beat <= beat + 2'd1;
        done  <= (nxt_ph == PH_IDLE);
      end else if (phase != PH_IDLE) begin
        cnt <= cnt - 6'd1;
      end
    end
  end

  assert_start_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> phase == PH_IDLE);
  assert_four_beats_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_PAGE && phase_end && beat == 2'd3) |=> phase != PH_PAGE);
  assert_page_only_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_PAGE |-> page_rd);
endmodule

// File: rtl/smc_rd_capture.sv
module smc_rd_capture #(
  parameter int DATA_W = 16,
  parameter int ITEMS  = 4,
  localparam int HALF_W = DATA_W / 2,
  localparam int IDX_W  = $clog2(ITEMS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear,
  input  logic                    take,
  input  logic [IDX_W-1:0]        idx,
  input  logic                    wide,
  input  logic [DATA_W-1:0]       din,
  output logic [ITEMS*DATA_W-1:0] words
);
  logic [DATA_W-1:0] sized;

  assign sized = wide ? din : {{(DATA_W-HALF_W){1'b0}}, din[HALF_W-1:0]};

  for (genvar k = 0; k < ITEMS; k++) begin : g_item
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              words[k*DATA_W +: DATA_W] <= '0;
      else if (clear)                          words[k*DATA_W +: DATA_W] <= '0;
      else if (take && idx == IDX_W'(k))       words[k*DATA_W +: DATA_W] <= sized;
    end
  end
endmodule

// File: rtl/smc_bank_seq.sv
module smc_bank_seq
  import smc_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int OFF_W     = 8,
  parameter int DATA_W    = 16,
  localparam int BANK_W = $clog2(NUM_BANKS),
  localparam int ADDR_W = BANK_W + OFF_W,
  localparam int ITEMS  = 4,
  localparam int HALF_W = DATA_W / 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic                        req_write,
  input  logic [BANK_W-1:0]           req_bank,
  input  logic [OFF_W-1:0]            req_off,
  input  logic [DATA_W-1:0]           req_wdata,
  output logic                        req_done,
  output logic [ITEMS*DATA_W-1:0]     rsp_data,
  input  logic [NUM_BANKS*TIM_W-1:0]  cfg_timing,
  input  logic [NUM_BANKS-1:0]        cfg_wide,
  input  logic [NUM_BANKS-1:0]        cfg_page4,
  output logic [ADDR_W-1:0]           mem_addr,
  output logic [NUM_BANKS-1:0]        mem_cs_n,
  output logic                        mem_oe_n,
  output logic                        mem_we_n,
  output logic [DATA_W-1:0]           mem_dout,
  input  logic [DATA_W-1:0]           mem_din
);
  logic [BANK_W-1:0] cur_bank;
  logic [OFF_W-1:0]  cur_off;
  logic              cur_wr;
  logic [DATA_W-1:0] cur_wdata;

  logic              accept;
  logic [BANK_W-1:0] sel_bank;
  logic              sel_wr;
  bank_tim_t         tim;
  logic              wide;
  logic              page4;
  logic              page_rd;
  phase_e            phase;
  logic [1:0]        beat;
  logic              sample;
  logic              busy;
  logic              cs_window;
  logic              strobe;
  logic [1:0]        low_bits;

  assign accept   = req_valid && req_ready;
  assign sel_bank = req_ready ? req_bank  : cur_bank;
  assign sel_wr   = req_ready ? req_write : cur_wr;
  assign page_rd  = page4 && !sel_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_bank  <= '0;
      cur_off   <= '0;
      cur_wr    <= 1'b0;
      cur_wdata <= '0;
    end else if (accept) begin
      cur_bank  <= req_bank;
      cur_off   <= req_off;
      cur_wr    <= req_write;
      cur_wdata <= req_wdata;
    end
  end

  smc_bank_cfg #(.NUM_BANKS(NUM_BANKS)) u_cfg (
    .cfg_timing (cfg_timing),
    .cfg_wide   (cfg_wide),
    .cfg_page4  (cfg_page4),
    .sel        (sel_bank),
    .tim        (tim),
    .wide       (wide),
    .page4      (page4)
  );

  smc_phase_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (accept),
    .page_rd (page_rd),
    .tim     (tim),
    .phase   (phase),
    .beat    (beat),
    .sample  (sample),
    .done    (req_done)
  );

  smc_rd_capture #(.DATA_W(DATA_W), .ITEMS(ITEMS)) u_cap (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (accept),
    .take  (sample && !cur_wr),
    .idx   (beat),
    .wide  (wide),
    .din   (mem_din),
    .words (rsp_data)
  );

  assign busy      = (phase != PH_IDLE);
  assign req_ready = !busy;
  assign cs_window = (phase == PH_CSU) || (phase == PH_ACC) ||
                     (phase == PH_PAGE) || (phase == PH_CHD);
  assign strobe    = (phase == PH_ACC) || (phase == PH_PAGE);
  assign low_bits  = cur_off[1:0] + beat;

  assign mem_addr  = busy ? {cur_bank, cur_off[OFF_W-1:2], low_bits} : '0;
  assign mem_oe_n  = !(strobe && !cur_wr);
  assign mem_we_n  = !(strobe && cur_wr);
  assign mem_dout  = (busy && cur_wr) ?
                     (wide ? cur_wdata : {{(DATA_W-HALF_W){1'b0}}, cur_wdata[HALF_W-1:0]}) : '0;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_cs
    assign mem_cs_n[b] = !(cs_window && cur_bank == BANK_W'(b));
  end

  assert_single_cs_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~mem_cs_n));
  assert_strobe_in_cs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n || !mem_we_n) |-> (mem_cs_n != {NUM_BANKS{1'b1}}));
  assert_no_dual_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n));
  assert_narrow_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && !wide) |-> mem_dout[DATA_W-1:HALF_W] == '0);
  assert_hold_after_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);
  assert_done_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_done |-> req_ready);
endmodule

// File: tb/smc_bank_seq_test.sv
`timescale 1ns/1ps
module smc_bank_seq_test;
  localparam int NB = 4;
  localparam int OW = 8;
  localparam int DW = 16;
  localparam int AW = 10;
  localparam int TW = 25;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic req_write = 1'b0;
  logic [1:0] req_bank = '0;
  logic [OW-1:0] req_off = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_done;
  logic [4*DW-1:0] rsp_data;
  logic [NB*TW-1:0] cfg_timing = '0;
  logic [NB-1:0] cfg_wide = '0;
  logic [NB-1:0] cfg_page4 = '0;
  logic [AW-1:0] mem_addr;
  logic [NB-1:0] mem_cs_n;
  logic mem_oe_n, mem_we_n;
  logic [DW-1:0] mem_dout;
  logic [DW-1:0] mem_din;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [DW-1:0] store [1024];

  always #2 clk = ~clk;

  function automatic logic [DW-1:0] pat(logic [AW-1:0] a);
    return 16'({6'b0, a} * 16'd37) ^ 16'hA5C3;
  endfunction

  assign mem_din = pat(mem_addr);

  // R11: packing of one bank's timing field
  function automatic logic [TW-1:0] pack(int as_, int cs_, int acc, int ch, int ah, int pg);
    return {4'(as_), 4'(cs_), 5'(acc), 4'(ch), 4'(ah), 4'(pg)};
  endfunction

  function automatic logic [DW-1:0] sz(logic [DW-1:0] v, bit w);
    return w ? v : {8'h00, v[7:0]};
  endfunction

  smc_bank_seq uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_bank(req_bank), .req_off(req_off),
    .req_wdata(req_wdata), .req_done(req_done), .rsp_data(rsp_data),
    .cfg_timing(cfg_timing), .cfg_wide(cfg_wide), .cfg_page4(cfg_page4),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_dout(mem_dout), .mem_din(mem_din)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run(int b, int off, bit wr, int wd, bit wide, bit pg4,
                     int tas, int tcs, int tacc, int tch, int tah, int tpg);
    int n = 0, pre_cs = 0, csl = 0, cs_pre_stb = 0, stb = 0, bad_cs = 0, rdy_bad = 0;
    int pg_len, stb_exp, cs_exp, busy_exp, first_addr = -1;
    bit seen_cs = 0, seen_stb = 0;
    cfg_timing[b*TW +: TW] = pack(tas, tcs, tacc, tch, tah, tpg);
    cfg_wide[b]  = wide;
    cfg_page4[b] = pg4;
    @(negedge clk);
    chk(req_ready == 1'b1, "R10 ready before request", int'(req_ready), 1);
    req_valid = 1'b1; req_write = wr; req_bank = 2'(b); req_off = 8'(off); req_wdata = 16'(wd);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!req_done && n < 400) begin
      n++;
      if (n == 1) first_addr = int'(mem_addr);
      if (mem_cs_n != 4'hF) begin
        seen_cs = 1; csl++;
        if (mem_cs_n != ~(4'b1 << b)) bad_cs++;
      end else if (!seen_cs) pre_cs++;
      if (!mem_oe_n || !mem_we_n) begin seen_stb = 1; stb++; end
      else if (seen_cs && !seen_stb) cs_pre_stb++;
      if (!mem_we_n) store[mem_addr] = mem_dout;
      if (req_ready) rdy_bad++;
      @(negedge clk);
    end
    pg_len   = (!wr && pg4) ? 3 * ((tpg == 0) ? 1 : tpg) : 0;
    stb_exp  = tacc + 1 + pg_len;
    cs_exp   = tcs + stb_exp + tch;
    busy_exp = tas + cs_exp + tah;
    chk(n == busy_exp, "R5 R6 busy cycles", n, busy_exp);
    chk(req_ready == 1'b1, "R5 ready with done", int'(req_ready), 1);
    chk(pre_cs == tas, "R2 R6 address setup", pre_cs, tas);
    chk(cs_pre_stb == tcs, "R3 R6 cs setup", cs_pre_stb, tcs);
    chk(stb == stb_exp, "R4 R9 strobe cycles", stb, stb_exp);
    chk(csl == cs_exp, "R5 cs low cycles", csl, cs_exp);
    chk(bad_cs == 0, "R1 wrong chip select", bad_cs, 0);
    chk(first_addr == b * 256 + off, "R1 bus address", first_addr, b * 256 + off);
    chk(rdy_bad == 0, "R10 ready while busy", rdy_bad, 0);
    if (wr) begin
      chk(store[b*256+off] == sz(16'(wd), wide), "R8 written data",
          int'(store[b*256+off]), int'(sz(16'(wd), wide)));
    end else begin
      for (int k = 0; k < (pg4 ? 4 : 1); k++) begin
        int a = b * 256 + (off & 8'hFC) + ((off + k) & 3);
        int e = int'(sz(pat(10'(a)), wide));
        chk(int'(rsp_data[k*DW +: DW]) == e, pg4 ? "R9 page item" : "R7 read data",
            int'(rsp_data[k*DW +: DW]), e);
      end
    end
  endtask

  initial begin
    #1;
    chk(mem_cs_n == 4'hF, "R12 cs after reset", int'(mem_cs_n), 15);
    chk(mem_oe_n && mem_we_n, "R12 strobes after reset", int'({mem_oe_n, mem_we_n}), 3);
    chk(req_ready == 1'b1, "R12 ready after reset", int'(req_ready), 1);
    chk(req_done == 1'b0, "R12 done after reset", int'(req_done), 0);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    for (int c = 0; c < 6; c++) begin
      for (int b = 0; b < 4; b++) begin
        for (int wr = 0; wr < 2; wr++) begin
          for (int pg = 0; pg < 2; pg++) begin
            int tas, tcs, tacc, tch, tah, tpg, off, wd;
            if (c == 1) begin tas = 15; tcs = 15; tacc = 31; tch = 15; tah = 15; tpg = 15; end
            else begin
              tas = (c*3)%16; tcs = (c*7)%16; tacc = (c*11)%32;
              tch = (c*5)%16; tah = (c*13)%16; tpg = (c*9)%16;
            end
            off = (c*53 + b*17 + wr*5 + pg*2) & 255;
            wd  = (c*4099 + b*771 + pg*313 + 16'h1234) & 16'hFFFF;
            run(b, off, wr[0], wd, b[0] ^ c[0], pg[0], tas, tcs, tacc, tch, tah, tpg);
          end
        end
      end
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule